// File: doc/BRIEF.md
# GPIO Task and Event Channel Unit

This unit sits between a general-purpose I/O register block and the pad outputs. It holds a small set of channels. Each channel is configured through one register that names a pin, a mode and a polarity.

In task mode a channel takes the pin over and drives it. It drives the pin high on a set strobe and low on a clear strobe. On an out strobe it drives high, drives low, toggles or leaves the pin alone, as the polarity field selects. In event mode a channel turns the pin into an input and watches it. It latches a sticky flag when the synchronized pin value shows the selected edge.

A pin that no channel claims passes the output value and direction from the GPIO register block straight through. Configuration and flags are reached over a plain synchronous write port and a read port with one cycle of latency. Both ports are always ready, so they carry no back-pressure. The task strobes are single-cycle pulses with no handshake.

Top module: `pin_task_unit`

## Requirements
- R1: After reset every configuration register reads 0 (disconnected), every event flag reads 0, and `pin_out`/`pin_dir` equal `gpio_out_reg`/`gpio_dir_reg`.
- R2: Channel n's configuration sits at address n. Its fields are pin select in bits [4:0], mode in bits [9:8], polarity in bits [13:12] and initial value in bit 16. A read returns the stored word on `rd_data` one cycle after `rd_en`. Mode 0 is disconnected, 1 is event and 3 is task; the value 2 is stored but acts as disconnected.
- R3: When a configuration write moves a channel into task mode, the channel's output value is loaded from the initial value bit. The selected pin then has `pin_dir`=1 and `pin_out` equal to that value.
- R4: In task mode a set strobe drives the pin high and a clear strobe drives it low, from the next cycle on. When both arrive on one channel in the same cycle, the pin goes low.
- R5: In task mode an out strobe acts by polarity: 1 drives the pin high, 2 drives it low, 3 inverts it, and 0 leaves it unchanged.
- R6: While a channel owns a pin, changes of `gpio_out_reg` for that pin do not reach `pin_out`. Task strobes on a channel that is not in task mode have no effect on any pin.
- R7: When a channel is set back to disconnected, its pin returns to `gpio_out_reg` and `gpio_dir_reg`.
- R8: In event mode the selected pin has `pin_dir`=0 and `pin_out`=0. The input passes through two flip-flops before edge detection, so a change applied before clock edge k sets the flag at edge k+2. Polarity 1 responds to a rising edge only, 2 to a falling edge only, and 3 to either edge.
- R9: Channel n's event flag is bit 0 at address 4+n. It stays set until a write with bit 0 equal to 0 clears it. A write with bit 0 equal to 1 does not set it. An edge arriving in the same cycle as a clear leaves the flag set.
- R10: When several channels select one pin, a channel in task mode beats any channel in event mode, and among task-mode channels the lowest-numbered one drives the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| task_set | input | 4 | Per-channel set strobe |
| task_clr | input | 4 | Per-channel clear strobe |
| task_out | input | 4 | Per-channel polarity-controlled out strobe |
| gpio_out_reg | input | 32 | Output values from the GPIO register block |
| gpio_dir_reg | input | 32 | Directions from the GPIO register block (1 = output) |
| pin_in | input | 32 | Asynchronous pad input values |
| pin_out | output | 32 | Pad output values |
| pin_dir | output | 32 | Pad directions (1 = output) |

## Verification
The out strobe is run through every pairing of polarity with starting value 0 or 1. This separates drive-high, drive-low, toggle and no-op, which would look alike if only one starting level were used. The strobe tests apply set and clear alone and then together, which shows whether clear wins. Edge detection is run with rising and falling edges under the rise-only and either-edge polarities, and the flag is read one cycle before and one cycle after it should appear, which fixes the synchronizer depth. Pins shared by several channels are driven by task channels that hold different values, so the read-back pin level shows which channel wins.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_EVT  = 2'd1;
  localparam logic [1:0] MODE_TASK = 2'd3;

  localparam logic [1:0] POL_NONE = 2'd0;
  localparam logic [1:0] POL_HIGH = 2'd1;
  localparam logic [1:0] POL_LOW  = 2'd2;
  localparam logic [1:0] POL_TOG  = 2'd3;

  localparam int MODE_LSB = 8;
  localparam int POL_LSB  = 12;
  localparam int INIT_BIT = 16;
  localparam int WORD_W   = 32;
endpackage

// File: rtl/ptu_pin_sync.sv
module ptu_pin_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] sync_now,
  output logic [NUM_PINS-1:0] sync_old
);
  logic [NUM_PINS-1:0] stage1_q, stage2_q, last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      last_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      last_q   <= stage2_q;
    end
  end

  assign sync_now = stage2_q;
  assign sync_old = last_q;

  // R8
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_old == $past(sync_now)));
endmodule

// File: rtl/ptu_channel.sv
module ptu_channel
  import ptu_pkg::*;
#(
  parameter int NUM_PINS = 32,
  localparam int PSW = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                flag_we,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                task_set,
  input  logic                task_clr,
  input  logic                task_out,
  input  logic [NUM_PINS-1:0] sync_now,
  input  logic [NUM_PINS-1:0] sync_old,
  output logic [PSW-1:0]      pin_sel,
  output logic                is_task,
  output logic                is_evt,
  output logic                tval,
  output logic                flag,
  output logic [WORD_W-1:0]   cfg_word
);
  logic [PSW-1:0] sel_q;
  logic [1:0]     mode_q, pol_q;
  logic           init_q;
  logic           tval_q, flag_q;
  logic           enter_task, edge_hit, cur_v, old_v, clr_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= MODE_OFF;
      pol_q  <= POL_NONE;
      init_q <= 1'b0;
    end else if (cfg_we) begin
      sel_q  <= wdata[PSW-1:0];
      mode_q <= wdata[MODE_LSB +: 2];
      pol_q  <= wdata[POL_LSB +: 2];
      init_q <= wdata[INIT_BIT];
    end
  end

  assign is_task    = (mode_q == MODE_TASK);
  assign is_evt     = (mode_q == MODE_EVT);
  assign enter_task = cfg_we && (wdata[MODE_LSB +: 2] == MODE_TASK) && !is_task;

  // Task output value keeps its content through reset; it is reloaded on task entry.
  always_ff @(posedge clk) begin
    if (enter_task) begin
      tval_q <= wdata[INIT_BIT];
    end else if (is_task) begin
      if (task_clr) begin
        tval_q <= 1'b0;
      end else if (task_set) begin
        tval_q <= 1'b1;
      end else if (task_out) begin
        case (pol_q)
          POL_HIGH: tval_q <= 1'b1;
          POL_LOW:  tval_q <= 1'b0;
          POL_TOG:  tval_q <= ~tval_q;
          default:  tval_q <= tval_q;
        endcase
      end
    end
  end

  assign cur_v = sync_now[sel_q];
  assign old_v = sync_old[sel_q];

  always_comb begin
    case (pol_q)
      POL_HIGH: edge_hit = cur_v & ~old_v;
      POL_LOW:  edge_hit = ~cur_v & old_v;
      POL_TOG:  edge_hit = cur_v ^ old_v;
      default:  edge_hit = 1'b0;
    endcase
  end

  assign clr_req = flag_we && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (is_evt && edge_hit) begin
      flag_q <= 1'b1;
    end else if (clr_req) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[PSW-1:0]        = sel_q;
    cfg_word[MODE_LSB +: 2]  = mode_q;
    cfg_word[POL_LSB +: 2]   = pol_q;
    cfg_word[INIT_BIT]       = init_q;
  end

  assign pin_sel = sel_q;
  assign tval    = tval_q;
  assign flag    = flag_q;

  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_task && task_clr) |=> !tval_q);
  // R4
  set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_task && task_set && !task_clr) |=> tval_q);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_task && !enter_task) |=> $stable(tval_q));
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q);
  // R8
  flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(is_evt));
endmodule

// File: rtl/ptu_pin_mux.sv
module ptu_pin_mux #(
  parameter int NUM_CH   = 4,
  parameter int NUM_PINS = 32,
  localparam int PSW = $clog2(NUM_PINS)
) (
  input  logic [NUM_CH-1:0][PSW-1:0] ch_sel,
  input  logic [NUM_CH-1:0]          ch_task,
  input  logic [NUM_CH-1:0]          ch_evt,
  input  logic [NUM_CH-1:0]          ch_tval,
  input  logic [NUM_PINS-1:0]        gpio_out_reg,
  input  logic [NUM_PINS-1:0]        gpio_dir_reg,
  output logic [NUM_PINS-1:0]        pin_out,
  output logic [NUM_PINS-1:0]        pin_dir
);
  always_comb begin
    pin_out = gpio_out_reg;
    pin_dir = gpio_dir_reg;
    for (int p = 0; p < NUM_PINS; p++) begin
      // Event claims first, then task claims; descending order lets the lowest channel win.
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (ch_evt[c] && (ch_sel[c] == PSW'(p))) begin
          pin_out[p] = 1'b0;
          pin_dir[p] = 1'b0;
        end
      end
      for (int c = NUM_CH - 1; c >= 0; c--) begin
        if (ch_task[c] && (ch_sel[c] == PSW'(p))) begin
          pin_out[p] = ch_tval[c];
          pin_dir[p] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pin_task_unit.sv
module pin_task_unit
  import ptu_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_PINS = 32,
  localparam int AW  = $clog2(2 * NUM_CH),
  localparam int PSW = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [NUM_CH-1:0]   task_set,
  input  logic [NUM_CH-1:0]   task_clr,
  input  logic [NUM_CH-1:0]   task_out,
  input  logic [NUM_PINS-1:0] gpio_out_reg,
  input  logic [NUM_PINS-1:0] gpio_dir_reg,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_dir
);
  logic [NUM_PINS-1:0]             sync_now, sync_old;
  logic [NUM_CH-1:0][PSW-1:0]      ch_sel;
  logic [NUM_CH-1:0]               ch_task, ch_evt, ch_tval, ch_flag;
  logic [NUM_CH-1:0][WORD_W-1:0]   ch_cfg;
  logic [WORD_W-1:0]               rd_mux, rd_q;

  ptu_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .sync_now (sync_now),
    .sync_old (sync_old)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ptu_channel #(.NUM_PINS(NUM_PINS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (wr_en && (wr_addr == AW'(c))),
      .flag_we  (wr_en && (wr_addr == AW'(NUM_CH + c))),
      .wdata    (wr_data),
      .task_set (task_set[c]),
      .task_clr (task_clr[c]),
      .task_out (task_out[c]),
      .sync_now (sync_now),
      .sync_old (sync_old),
      .pin_sel  (ch_sel[c]),
      .is_task  (ch_task[c]),
      .is_evt   (ch_evt[c]),
      .tval     (ch_tval[c]),
      .flag     (ch_flag[c]),
      .cfg_word (ch_cfg[c])
    );
  end

  ptu_pin_mux #(.NUM_CH(NUM_CH), .NUM_PINS(NUM_PINS)) u_mux (
    .ch_sel       (ch_sel),
    .ch_task      (ch_task),
    .ch_evt       (ch_evt),
    .ch_tval      (ch_tval),
    .gpio_out_reg (gpio_out_reg),
    .gpio_dir_reg (gpio_dir_reg),
    .pin_out      (pin_out),
    .pin_dir      (pin_dir)
  );

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == AW'(c))          rd_mux = ch_cfg[c];
      if (rd_addr == AW'(NUM_CH + c)) rd_mux = {{(WORD_W-1){1'b0}}, ch_flag[c]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_en)  rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  // R10
  ch0_owns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_task[0] |-> ((pin_out[ch_sel[0]] == ch_tval[0]) && pin_dir[ch_sel[0]]));
  // R8
  evt_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_evt[0] && !(|ch_task)) |-> (!pin_dir[ch_sel[0]] && !pin_out[ch_sel[0]]));
endmodule

// File: tb/tb_pin_task_unit.sv
module tb_pin_task_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  task_set, task_clr, task_out;
  logic [31:0] gpio_out_reg, gpio_dir_reg, pin_in, pin_out, pin_dir;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] v;

  always #5 clk = ~clk;

  pin_task_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .task_set(task_set), .task_clr(task_clr), .task_out(task_out),
    .gpio_out_reg(gpio_out_reg), .gpio_dir_reg(gpio_dir_reg), .pin_in(pin_in),
    .pin_out(pin_out), .pin_dir(pin_dir)
  );

  // Entry: {polarity[1:0], start value, expected after one out strobe}
  localparam logic [3:0] VEC [8] = '{
    4'b01_0_1, 4'b01_1_1, 4'b10_0_0, 4'b10_1_0,
    4'b11_0_1, 4'b11_1_0, 4'b00_0_0, 4'b00_1_1
  };

  function automatic logic [31:0] cfg(input int pin, input int mode, input int pol, input bit init);
    logic [31:0] w = '0;
    w[4:0]   = 5'(pin);
    w[9:8]   = 2'(mode);
    w[13:12] = 2'(pol);
    w[16]    = init;
    return w;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input logic [3:0] s, input logic [3:0] c, input logic [3:0] o);
    task_set = s; task_clr = c; task_out = o;
    @(negedge clk);
    task_set = '0; task_clr = '0; task_out = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    task_set = 0; task_clr = 0; task_out = 0;
    gpio_out_reg = 32'hA5A5_0F0F; gpio_dir_reg = 32'h0000_FFFF; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pin_out, 32'hA5A5_0F0F, "R1 pin_out");
    chk(pin_dir, 32'h0000_FFFF, "R1 pin_dir");
    rd(3'd0, v); chk(v, 32'h0, "R1 cfg0");
    rd(3'd4, v); chk(v, 32'h0, "R1 flag0");

    // R5/R3 table walk on channel 0, pin 5
    foreach (VEC[i]) begin
      wr(3'd0, cfg(5, 0, 0, 0));
      wr(3'd0, cfg(5, 3, int'(VEC[i][3:2]), VEC[i][1]));
      chk({31'b0, pin_out[5]}, {31'b0, VEC[i][1]}, "R3 init load");
      chk({31'b0, pin_dir[5]}, 32'h1, "R3 dir out");
      pulse(4'b0000, 4'b0000, 4'b0001);
      chk({31'b0, pin_out[5]}, {31'b0, VEC[i][0]}, "R5 out task");
    end
    wr(3'd0, cfg(0, 0, 0, 0));

    // R2 readback, mode 2 acts as disconnected (R7)
    wr(3'd1, cfg(9, 2, 3, 1));
    rd(3'd1, v); chk(v, cfg(9, 2, 3, 1), "R2 readback");
    chk({31'b0, pin_out[9]}, 32'h1, "R2 mode2 out");
    chk({31'b0, pin_dir[9]}, 32'h1, "R2 mode2 dir");

    // R4 set/clear on channel 1, pin 9
    wr(3'd1, cfg(9, 3, 0, 0));
    chk({31'b0, pin_out[9]}, 32'h0, "R3 init0");
    pulse(4'b0010, 4'b0000, 4'b0000);
    chk({31'b0, pin_out[9]}, 32'h1, "R4 set");
    pulse(4'b0000, 4'b0010, 4'b0000);
    chk({31'b0, pin_out[9]}, 32'h0, "R4 clear");
    pulse(4'b0010, 4'b0010, 4'b0000);
    chk({31'b0, pin_out[9]}, 32'h0, "R4 clear wins");

    // R6 GPIO writes ignored on owned pin
    gpio_out_reg[9] = 1'b1; @(negedge clk);
    chk({31'b0, pin_out[9]}, 32'h0, "R6 gpio ignored");
    gpio_out_reg[9] = 1'b0; @(negedge clk);
    pulse(4'b0010, 4'b0000, 4'b0000);
    gpio_out_reg[9] = 1'b0; @(negedge clk);
    chk({31'b0, pin_out[9]}, 32'h1, "R6 gpio ignored low");
    // R6 tasks on a disconnected channel do nothing
    wr(3'd3, cfg(7, 0, 1, 0));
    pulse(4'b1000, 4'b0000, 4'b1000);
    chk(pin_out & ~32'h200, 32'hA5A5_0D0F & ~32'h200, "R6 idle channel");

    // R7 disconnect returns to GPIO
    gpio_out_reg[9] = 1'b0; gpio_dir_reg[9] = 1'b0;
    wr(3'd1, cfg(9, 0, 0, 0));
    chk({31'b0, pin_out[9]}, 32'h0, "R7 fallback out");
    chk({31'b0, pin_dir[9]}, 32'h0, "R7 fallback dir");
    gpio_out_reg[9] = 1'b1; @(negedge clk);
    chk({31'b0, pin_out[9]}, 32'h1, "R7 follows gpio");

    // R8 event mode on channel 2, pin 12, rising only
    gpio_out_reg[12] = 1'b1;
    wr(3'd2, cfg(12, 1, 1, 0));
    chk({31'b0, pin_dir[12]}, 32'h0, "R8 dir in");
    chk({31'b0, pin_out[12]}, 32'h0, "R8 out low");
    pulse(4'b0100, 4'b0000, 4'b0100);
    chk({31'b0, pin_out[12]}, 32'h0, "R6 task in event mode");
    pin_in[12] = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd6, v); chk(v, 32'h0, "R8 sync latency early");
    rd(3'd6, v); chk(v, 32'h1, "R8 rising flag");
    repeat (10) @(negedge clk);
    rd(3'd6, v); chk(v, 32'h1, "R9 sticky");
    wr(3'd6, 32'h0);
    rd(3'd6, v); chk(v, 32'h0, "R9 clear");
    wr(3'd6, 32'h1);
    rd(3'd6, v); chk(v, 32'h0, "R9 write one no set");
    pin_in[12] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd6, v); chk(v, 32'h0, "R8 falling ignored");
    wr(3'd2, cfg(12, 1, 3, 0));
    pin_in[12] = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd6, v); chk(v, 32'h1, "R8 either edge");
    wr(3'd6, 32'h0);
    wr(3'd2, cfg(12, 1, 2, 0));
    pin_in[12] = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd6, v); chk(v, 32'h1, "R8 falling edge");

    // R10 shared pin 20
    wr(3'd1, cfg(20, 3, 0, 1));
    wr(3'd3, cfg(20, 3, 0, 0));
    chk({31'b0, pin_out[20]}, 32'h1, "R10 lowest wins");
    wr(3'd1, cfg(20, 0, 0, 0));
    chk({31'b0, pin_out[20]}, 32'h0, "R10 next channel");
    wr(3'd2, cfg(20, 1, 1, 0));
    pulse(4'b1000, 4'b0000, 4'b0000);
    chk({31'b0, pin_out[20]}, 32'h1, "R10 task over event out");
    chk({31'b0, pin_dir[20]}, 32'h1, "R10 task over event dir");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule